// File: doc/BRIEF.md
# Flash Command Engine

This block runs the commands of an on-chip flash array that is built from rows of four pages each. A page-sized staging buffer collects bytes through a valid/ready write port. Software-side logic then issues commands on a plain command port. The block can erase a row, program a page, erase or program the auxiliary lock word, lock or unlock a region, clear the staging buffer, raise the security bit, or erase the whole chip. Erase and program take a fixed number of cycles, and `ready` is low while they run. The flash itself is a synthesizable behavioural model. Erasing sets every bit to one. Programming can only clear bits, so programming a page that was not erased first leaves corrupted data behind.

The page number is `row*4 + page_in_row`, and the byte address is `page*PAGE_BYTES + offset`. The array is split into `LOCK_REGIONS` equal lock regions, and the region index is the upper bits of the page number. Rows in the emulated-EEPROM area at the top of the array ignore locks. On reset, the live lock state is loaded from the auxiliary lock word, where a bit value of 0 means locked. The auxiliary word and the security bit are nonvolatile and are not changed by reset.

Write port rules: a byte moves when `wr_valid && wr_ready` at a rising edge. `wr_ready` is low while a command runs and while `cmd_valid` is high. The sender holds `wr_addr` and `wr_data` stable until the byte is taken.

Top module: `flash_cmd_engine`

## Requirements
- R1: Erase-row (`cmd_op`=0) is accepted while `ready`=1, holds `ready` low for ERASE_CYC cycles, then leaves every byte of the four pages of row `cmd_addr[8:5]` at 8'hFF and other rows unchanged.
- R2: Write-page (`cmd_op`=1) holds `ready` low for PROG_CYC cycles. Each byte of the addressed page then becomes its old value AND the staging byte. After the program the staging buffer returns to all 8'hFF.
- R3: With `auto_commit`=1, a byte taken at offset PAGE_BYTES-1 starts a program of that byte's page by itself. With `auto_commit`=0, a full buffer programs nothing.
- R4: A partially filled buffer changes no flash byte until an explicit write-page command arrives, in either mode.
- R5: Clear-buffer (`cmd_op`=6) sets every staging byte to 8'h00.
- R6: After reset, `ready`=1 and all error and reject flags are 0. A command offered while `ready`=0 is dropped, and `cmd_reject` is 1 in the next cycle. `wr_ready` is 0 whenever `ready`=0.
- R7: Lock (`cmd_op`=4) sets and unlock (`cmd_op`=5) clears `lock_state[cmd_addr[8:5]]` at once. Reset reloads `lock_state` as the inverse of the auxiliary word. Aux-program (`cmd_op`=3) ANDs staging bytes 0..1 into that word.
- R8: The top EE_ROWS rows are erased and programmed normally even when their region is locked.
- R9: While `sec_bit`=1, aux-erase (2), aux-program (3), lock and unlock are refused with `err_lock` and no other effect. Set-security (7) raises `sec_bit`. Chip-erase (8) takes ERASE_CYC cycles and sets the array and the aux word to all ones, `lock_state` to 0 and `sec_bit` to 0.
- R10: An erase or program aimed at a locked, non-EEPROM page is not started. It sets `err_lock` and `sec_bit` in the next cycle and `ready` stays 1.
- R11: Any `cmd_op` above 8 sets `err_prog`.
- R12: An `err_rd` strobe places {`err_prog`,`err_lock`} on `err_rdata` in the next cycle and clears both flags in that same cycle.
- R13: `rd_en` returns the array byte at `rd_addr` on `rd_data` with `rd_valid`=1 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| auto_commit | input | 1 | 1: filling the last buffer byte starts a program |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Command code |
| cmd_addr | input | AW | Byte address of the command target |
| cmd_reject | output | 1 | Previous-cycle command dropped because busy |
| ready | output | 1 | Engine idle, commands accepted |
| wr_valid | input | 1 | Staging byte valid |
| wr_ready | output | 1 | Staging byte accepted this cycle |
| wr_addr | input | AW | Byte address (offset selects staging byte) |
| wr_data | input | 8 | Staging byte value |
| rd_en | input | 1 | Array read strobe |
| rd_addr | input | AW | Array read byte address |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| err_rd | input | 1 | Read-and-clear of error flags |
| err_rdata | output | 2 | {prog, lock} captured by the last err_rd |
| err_lock | output | 1 | Lock/security violation flag |
| err_prog | output | 1 | Invalid command flag |
| sec_bit | output | 1 | Security bit |
| lock_state | output | LOCK_REGIONS | Live lock bits, 1 = locked |

## Verification
Immediate commands (lock, unlock, clear, set-security, refusals, invalid codes) and the error read-clear show their effect one cycle after the accepting edge. The bench samples these at the next falling edge. Erase and program results are only valid once `ready` rises again, ERASE_CYC or PROG_CYC cycles after acceptance. The bench waits for `ready` before it reads the array. Each array read is queued with its expected byte when `rd_en` is driven, and the monitor compares it on the falling edge that follows the one-cycle read latency.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int PAGES_PER_ROW = 4;

  typedef enum logic [3:0] {
    OP_ERASE_ROW  = 4'd0,
    OP_WRITE_PAGE = 4'd1,
    OP_ERASE_AUX  = 4'd2,
    OP_WRITE_AUX  = 4'd3,
    OP_LOCK       = 4'd4,
    OP_UNLOCK     = 4'd5,
    OP_CLEAR_BUF  = 4'd6,
    OP_SET_SEC    = 4'd7,
    OP_CHIP_ERASE = 4'd8
  } op_e;

  typedef enum logic [2:0] {
    JOB_ROW_ERASE,
    JOB_PAGE_PROG,
    JOB_AUX_ERASE,
    JOB_AUX_PROG,
    JOB_CHIP_ERASE
  } job_e;

endpackage

// File: rtl/flash_page_buf.sv
module flash_page_buf #(
  parameter int PAGE_BYTES = 8,
  localparam int OFFW = $clog2(PAGE_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [OFFW-1:0]         wr_off,
  input  logic [7:0]              wr_data,
  input  logic                    zero_all,
  input  logic                    ones_all,
  output logic [PAGE_BYTES*8-1:0] bytes_o
);

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_byte
    logic [7:0] slot;
    always_ff @(posedge clk) begin
      if (!rst_n)                                slot <= 8'hFF;
      else if (zero_all)                         slot <= 8'h00;
      else if (ones_all)                         slot <= 8'hFF;
      else if (wr_en && wr_off == OFFW'(g))      slot <= wr_data;
    end
    assign bytes_o[g*8 +: 8] = slot;
  end

endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
  parameter int NUM_PAGES  = 64,
  parameter int PAGE_BYTES = 8,
  localparam int OFFW = $clog2(PAGE_BYTES),
  localparam int PGW  = $clog2(NUM_PAGES),
  localparam int RW   = PGW - 2,
  localparam int AW   = PGW + OFFW
) (
  input  logic                    clk,
  input  logic                    row_erase_en,
  input  logic [RW-1:0]           row_idx,
  input  logic                    page_prog_en,
  input  logic [PGW-1:0]          page_idx,
  input  logic [PAGE_BYTES*8-1:0] prog_data,
  input  logic                    chip_erase_en,
  input  logic                    rd_en,
  input  logic [AW-1:0]           rd_addr,
  output logic [7:0]              rd_data
);

  logic [PAGE_BYTES*8-1:0] pages [NUM_PAGES];

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    logic [PAGE_BYTES*8-1:0] cells;
    always_ff @(posedge clk) begin
      if (chip_erase_en || (row_erase_en && row_idx == RW'(p / 4)))
        cells <= '1;
      else if (page_prog_en && page_idx == PGW'(p))
        cells <= cells & prog_data;
    end
    assign pages[p] = cells;
  end

  logic [PGW-1:0]  rd_page;
  logic [OFFW-1:0] rd_off;
  assign rd_page = rd_addr[AW-1:OFFW];
  assign rd_off  = rd_addr[OFFW-1:0];

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= pages[rd_page][{rd_off, 3'b000} +: 8];
  end

endmodule

// File: rtl/flash_lock_ctl.sv
module flash_lock_ctl #(
  parameter int LOCK_REGIONS = 16,
  localparam int REGW = $clog2(LOCK_REGIONS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lock_set,
  input  logic                    lock_clr,
  input  logic [REGW-1:0]         region,
  input  logic                    aux_erase,
  input  logic                    aux_prog,
  input  logic [LOCK_REGIONS-1:0] aux_data,
  input  logic                    sec_set,
  input  logic                    chip_erase,
  output logic [LOCK_REGIONS-1:0] live_lock,
  output logic                    sec
);

  // nonvolatile lock word (1 = unlocked) and security bit: untouched by reset
  logic [LOCK_REGIONS-1:0] aux_word;

  always_ff @(posedge clk) begin
    if (chip_erase || aux_erase) aux_word <= '1;
    else if (aux_prog)           aux_word <= aux_word & aux_data;
  end

  always_ff @(posedge clk) begin
    if (chip_erase)   sec <= 1'b0;
    else if (sec_set) sec <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          live_lock <= ~aux_word;
    else if (chip_erase) live_lock <= '0;
    else if (lock_set)   live_lock[region] <= 1'b1;
    else if (lock_clr)   live_lock[region] <= 1'b0;
  end

endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import flash_cmd_pkg::*;
#(
  parameter int NUM_PAGES    = 64,
  parameter int PAGE_BYTES   = 8,
  parameter int LOCK_REGIONS = 16,
  parameter int EE_ROWS      = 2,
  parameter int ERASE_CYC    = 6,
  parameter int PROG_CYC     = 4,
  localparam int AW = $clog2(NUM_PAGES * PAGE_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    auto_commit,
  input  logic                    cmd_valid,
  input  logic [3:0]              cmd_op,
  input  logic [AW-1:0]           cmd_addr,
  output logic                    cmd_reject,
  output logic                    ready,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  input  logic [AW-1:0]           wr_addr,
  input  logic [7:0]              wr_data,
  input  logic                    rd_en,
  input  logic [AW-1:0]           rd_addr,
  output logic                    rd_valid,
  output logic [7:0]              rd_data,
  input  logic                    err_rd,
  output logic [1:0]              err_rdata,
  output logic                    err_lock,
  output logic                    err_prog,
  output logic                    sec_bit,
  output logic [LOCK_REGIONS-1:0] lock_state
);

  localparam int OFFW    = $clog2(PAGE_BYTES);
  localparam int PGW     = $clog2(NUM_PAGES);
  localparam int RW      = PGW - 2;
  localparam int REGW    = $clog2(LOCK_REGIONS);
  localparam int NUM_ROWS = NUM_PAGES / PAGES_PER_ROW;
  localparam int MAXLAT  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CW      = $clog2(MAXLAT + 1);
  localparam logic [RW-1:0] EE_ROW0 = RW'(NUM_ROWS - EE_ROWS);

  // ---------------- address decode ----------------
  logic [PGW-1:0]  cmd_page, wr_page, tgt_page;
  logic [OFFW-1:0] wr_off;
  logic [RW-1:0]   tgt_row;
  logic [REGW-1:0] tgt_region, cmd_region;
  logic            tgt_in_ee, tgt_locked;

  assign cmd_page   = cmd_addr[AW-1:OFFW];
  assign wr_page    = wr_addr[AW-1:OFFW];
  assign wr_off     = wr_addr[OFFW-1:0];
  assign cmd_region = cmd_page[PGW-1 -: REGW];

  // ---------------- handshake ----------------
  logic busy, go, wr_fire, auto_go;
  assign ready    = !busy;
  assign wr_ready = !busy && !cmd_valid;
  assign go       = cmd_valid && !busy;
  assign wr_fire  = wr_valid && wr_ready;
  assign auto_go  = wr_fire && auto_commit && (wr_off == OFFW'(PAGE_BYTES - 1));

  assign tgt_page   = auto_go ? wr_page : cmd_page;
  assign tgt_row    = tgt_page[PGW-1:2];
  assign tgt_region = tgt_page[PGW-1 -: REGW];
  assign tgt_in_ee  = (EE_ROWS > 0) && (tgt_row >= EE_ROW0);
  assign tgt_locked = lock_state[tgt_region] && !tgt_in_ee;

  // ---------------- command classification ----------------
  logic modify_req, lock_fault, sec_fault, bad_op, sec_gated;
  assign modify_req = auto_go || (go && (cmd_op == OP_ERASE_ROW || cmd_op == OP_WRITE_PAGE));
  assign lock_fault = modify_req && tgt_locked;
  assign sec_gated  = cmd_op == OP_ERASE_AUX || cmd_op == OP_WRITE_AUX ||
                      cmd_op == OP_LOCK || cmd_op == OP_UNLOCK;
  assign sec_fault  = go && sec_bit && sec_gated;
  assign bad_op     = go && (cmd_op > OP_CHIP_ERASE);

  logic start;
  job_e start_job;
  always_comb begin
    start     = 1'b0;
    start_job = JOB_ROW_ERASE;
    if (auto_go) begin
      start     = !tgt_locked;
      start_job = JOB_PAGE_PROG;
    end else if (go) begin
      case (cmd_op)
        OP_ERASE_ROW:  begin start = !tgt_locked; start_job = JOB_ROW_ERASE;  end
        OP_WRITE_PAGE: begin start = !tgt_locked; start_job = JOB_PAGE_PROG;  end
        OP_ERASE_AUX:  begin start = !sec_bit;    start_job = JOB_AUX_ERASE;  end
        OP_WRITE_AUX:  begin start = !sec_bit;    start_job = JOB_AUX_PROG;   end
        OP_CHIP_ERASE: begin start = 1'b1;        start_job = JOB_CHIP_ERASE; end
        default:       ;
      endcase
    end
  end

  logic [CW-1:0] start_lat;
  assign start_lat = (start_job == JOB_PAGE_PROG || start_job == JOB_AUX_PROG)
                     ? CW'(PROG_CYC - 1) : CW'(ERASE_CYC - 1);

  // ---------------- job timer ----------------
  logic [CW-1:0]  cnt;
  job_e           job;
  logic [PGW-1:0] job_page;
  logic           done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      job      <= JOB_ROW_ERASE;
      job_page <= '0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (start) begin
      busy     <= 1'b1;
      cnt      <= start_lat;
      job      <= start_job;
      job_page <= tgt_page;
    end
  end

  assign done = busy && (cnt == '0);

  // ---------------- status ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_lock   <= 1'b0;
      err_prog   <= 1'b0;
      err_rdata  <= 2'b00;
      cmd_reject <= 1'b0;
      rd_valid   <= 1'b0;
    end else begin
      cmd_reject <= cmd_valid && busy;
      rd_valid   <= rd_en;
      if (err_rd) err_rdata <= {err_prog, err_lock};
      if (lock_fault || sec_fault) err_lock <= 1'b1;
      else if (err_rd)             err_lock <= 1'b0;
      if (bad_op)                  err_prog <= 1'b1;
      else if (err_rd)             err_prog <= 1'b0;
    end
  end

  // ---------------- submodules ----------------
  logic [PAGE_BYTES*8-1:0] buf_bytes;

  flash_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_fire),
    .wr_off   (wr_off),
    .wr_data  (wr_data),
    .zero_all (go && cmd_op == OP_CLEAR_BUF),
    .ones_all (done && job == JOB_PAGE_PROG),
    .bytes_o  (buf_bytes)
  );

  flash_cell_array #(.NUM_PAGES(NUM_PAGES), .PAGE_BYTES(PAGE_BYTES)) u_cells (
    .clk           (clk),
    .row_erase_en  (done && job == JOB_ROW_ERASE),
    .row_idx       (job_page[PGW-1:2]),
    .page_prog_en  (done && job == JOB_PAGE_PROG),
    .page_idx      (job_page),
    .prog_data     (buf_bytes),
    .chip_erase_en (done && job == JOB_CHIP_ERASE),
    .rd_en         (rd_en),
    .rd_addr       (rd_addr),
    .rd_data       (rd_data)
  );

  flash_lock_ctl #(.LOCK_REGIONS(LOCK_REGIONS)) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .lock_set   (go && cmd_op == OP_LOCK && !sec_bit),
    .lock_clr   (go && cmd_op == OP_UNLOCK && !sec_bit),
    .region     (cmd_region),
    .aux_erase  (done && job == JOB_AUX_ERASE),
    .aux_prog   (done && job == JOB_AUX_PROG),
    .aux_data   (buf_bytes[LOCK_REGIONS-1:0]),
    .sec_set    ((go && cmd_op == OP_SET_SEC) || lock_fault),
    .chip_erase (done && job == JOB_CHIP_ERASE),
    .live_lock  (lock_state),
    .sec        (sec_bit)
  );

endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker
  import flash_cmd_pkg::*;
#(
  parameter int AW = 9,
  parameter int LOCK_REGIONS = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cmd_valid,
  input logic [3:0]              cmd_op,
  input logic                    cmd_reject,
  input logic                    ready,
  input logic                    wr_ready,
  input logic                    rd_en,
  input logic                    rd_valid,
  input logic                    err_rd,
  input logic                    err_lock,
  input logic                    err_prog,
  input logic                    sec_bit
);

  AST_REJECT_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !ready) |=> cmd_reject); // R6

  AST_NO_FILL_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !wr_ready); // R6

  AST_LOCKERR_SECURES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_lock) |-> sec_bit); // R10

  AST_SET_SECURITY: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && cmd_valid && cmd_op == OP_SET_SEC) |=> sec_bit); // R9

  AST_AUX_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && cmd_valid && sec_bit && (cmd_op == OP_ERASE_AUX || cmd_op == OP_WRITE_AUX))
      |=> (ready && err_lock)); // R9

  AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && cmd_valid && cmd_op > OP_CHIP_ERASE) |=> err_prog); // R11

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_rd && !cmd_valid) |=> !err_prog); // R12

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R13

endmodule

bind flash_cmd_engine flash_cmd_checker #(.AW(AW), .LOCK_REGIONS(LOCK_REGIONS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .cmd_reject (cmd_reject),
  .ready      (ready),
  .wr_ready   (wr_ready),
  .rd_en      (rd_en),
  .rd_valid   (rd_valid),
  .err_rd     (err_rd),
  .err_lock   (err_lock),
  .err_prog   (err_prog),
  .sec_bit    (sec_bit)
);

// File: tb/flash_cmd_engine_test.sv
`timescale 1ns/1ps
module flash_cmd_engine_test;
  import flash_cmd_pkg::*;

  localparam int AW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_commit = 1'b0;
  logic cmd_valid = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic cmd_reject, ready, wr_ready, rd_valid, err_lock, err_prog, sec_bit;
  logic wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic err_rd = 1'b0;
  logic [1:0] err_rdata;
  logic [15:0] lock_state;

  always #2 clk = ~clk;

  flash_cmd_engine uut (
    .clk(clk), .rst_n(rst_n), .auto_commit(auto_commit),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_reject(cmd_reject), .ready(ready),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .err_rd(err_rd), .err_rdata(err_rdata), .err_lock(err_lock), .err_prog(err_prog),
    .sec_bit(sec_bit), .lock_state(lock_state)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  string      req_q[$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares read data in order of issue
  always @(negedge clk) begin
    if (rd_valid && exp_q.size() > 0) begin
      logic [7:0] e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      chk(r, {24'd0, rd_data}, {24'd0, e});
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cmd(logic [3:0] op, int addr);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = AW'(addr);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic fill(int addr, logic [7:0] d);
    wr_valid = 1'b1; wr_addr = AW'(addr); wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd_expect(int addr, logic [7:0] e, string req);
    exp_q.push_back(e);
    req_q.push_back(req);
    rd_en = 1'b1; rd_addr = AW'(addr);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  task automatic err_read();
    err_rd = 1'b1;
    @(negedge clk);
    err_rd = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R6 reset state
    chk("R6 ready after reset", ready, 1);
    chk("R6 err_lock after reset", err_lock, 0);
    chk("R6 err_prog after reset", err_prog, 0);
    chk("R6 reject after reset", cmd_reject, 0);

    // R9 chip erase brings a known nonvolatile state
    cmd(OP_CHIP_ERASE, 0);
    chk("R9 chip erase busy", ready, 0);
    wait_ready();
    chk("R9 security cleared by chip erase", sec_bit, 0);
    do_reset();
    chk("R7 reset reload of erased aux word", lock_state, 16'h0000);
    rd_expect(12*8, 8'hFF, "R1 erased byte");

    // R3 manual mode: full buffer programs nothing
    auto_commit = 1'b0;
    for (int i = 0; i < 8; i++) fill(12*8 + i, 8'h10 + 8'(i));
    chk("R3 manual mode stays idle", ready, 1);
    rd_expect(12*8 + 7, 8'hFF, "R3 manual mode no program");
    // R2 explicit write page
    cmd(OP_WRITE_PAGE, 12*8);
    chk("R2 program busy", ready, 0);
    wait_ready();
    for (int i = 0; i < 8; i++) rd_expect(12*8 + i, 8'h10 + 8'(i), "R2 page programmed");

    // R3 auto mode
    auto_commit = 1'b1;
    for (int i = 0; i < 8; i++) fill(16*8 + i, 8'hA0 + 8'(i));
    chk("R3 auto commit started", ready, 0);
    wait_ready();
    rd_expect(16*8 + 3, 8'hA3, "R3 auto commit data");

    // R6 busy rejection, R1 row erase scope
    cmd(OP_ERASE_ROW, 3*32);
    chk("R1 erase busy", ready, 0);
    cmd(OP_SET_SEC, 0);
    chk("R6 busy reject pulse", cmd_reject, 1);
    chk("R6 rejected command no effect", sec_bit, 0);
    wait_ready();
    rd_expect(12*8, 8'hFF, "R1 row erased page 12");
    rd_expect(15*8 + 7, 8'hFF, "R1 row erased page 15");
    rd_expect(16*8, 8'hA0, "R1 neighbour row kept");

    // R4 partial page, R2 program over non-erased data
    fill(16*8, 8'h35);
    chk("R4 partial fill idle", ready, 1);
    rd_expect(16*8, 8'hA0, "R4 partial not committed");
    cmd(OP_WRITE_PAGE, 16*8);
    wait_ready();
    rd_expect(16*8, 8'h20, "R2 corrupted AND result");
    rd_expect(16*8 + 1, 8'hA1, "R2 buffer refilled with ones");

    // R5 clear buffer
    fill(20*8, 8'h77);
    cmd(OP_CLEAR_BUF, 0);
    cmd(OP_WRITE_PAGE, 20*8);
    wait_ready();
    rd_expect(20*8, 8'h00, "R5 cleared byte 0");
    rd_expect(20*8 + 7, 8'h00, "R5 cleared byte 7");

    // R8 EEPROM rows ignore locks
    cmd(OP_LOCK, 60*8);
    chk("R7 lock region 15", lock_state, 16'h8000);
    auto_commit = 1'b0;
    fill(60*8, 8'h12);
    cmd(OP_WRITE_PAGE, 60*8);
    chk("R8 program in EE row started", ready, 0);
    wait_ready();
    rd_expect(60*8, 8'h12, "R8 EE row programmed");
    cmd(OP_ERASE_ROW, 60*8);
    wait_ready();
    rd_expect(60*8, 8'hFF, "R8 EE row erased");
    chk("R8 no lock error", err_lock, 0);

    // R10 locked region
    cmd(OP_LOCK, 20*8);
    chk("R7 lock region 5", lock_state, 16'h8020);
    cmd(OP_ERASE_ROW, 20*8);
    chk("R10 locked erase not started", ready, 1);
    chk("R10 lock error", err_lock, 1);
    chk("R10 security set", sec_bit, 1);
    rd_expect(20*8, 8'h00, "R10 locked row intact");
    err_read();
    chk("R12 read returns lock flag", err_rdata, 2'b01);
    chk("R12 lock flag cleared", err_lock, 0);

    // R9 security refusals
    cmd(OP_UNLOCK, 20*8);
    chk("R9 unlock refused", lock_state, 16'h8020);
    chk("R9 unlock refusal error", err_lock, 1);
    err_read();
    cmd(OP_ERASE_AUX, 0);
    chk("R9 aux erase refused", ready, 1);
    chk("R9 aux erase refusal error", err_lock, 1);
    err_read();

    // R11 invalid opcode
    cmd(4'hC, 0);
    chk("R11 prog error", err_prog, 1);
    err_read();
    chk("R12 read returns prog flag", err_rdata, 2'b10);
    chk("R12 prog flag cleared", err_prog, 0);

    // R9 chip erase, R7 aux word reload
    cmd(OP_CHIP_ERASE, 0);
    wait_ready();
    chk("R9 chip erase clears security", sec_bit, 0);
    chk("R9 chip erase clears locks", lock_state, 16'h0000);
    rd_expect(20*8, 8'hFF, "R9 chip erase array");
    fill(0, 8'hFE);
    cmd(OP_WRITE_AUX, 0);
    wait_ready();
    chk("R7 live lock unchanged by aux program", lock_state, 16'h0000);
    do_reset();
    chk("R7 reset reloads aux lock word", lock_state, 16'h0001);

    repeat (4) @(negedge clk);
    chk("R13 all reads returned", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule